// File: doc/BRIEF.md
# Boot Stream Loader with Host Pacing

This block sits on the receiving side of a boot link driven by an external host. Bytes arrive one at a time on a simple valid/data input. The stream is a series of blocks. Each block opens with a sixteen-byte header that names a destination address, a byte count and a set of flags. The loader decodes each header. It then places the block's payload in memory through a write port with a valid/ready handshake, and packs the bytes into 32-bit words.

The host cannot see the loader's internal state, so the loader gives it a single pacing output, `host_wait`. The host samples this output before it offers each byte. While the output is high the loader takes nothing, and any byte offered in that time is dropped. A header flag can mark a block as a fill block. A fill block carries no payload in the stream, and the loader writes zeros over its whole span. Another flag marks the final block. When that block's last write has been accepted, the loader raises `boot_done` and presents the fixed entry address at which execution begins.

Top module: `boot_stream_loader`

## Requirements
- R1: While reset is held and in the cycle after it is released, `host_wait`, `mem_valid` and `boot_done` are all low.
- R2: The header is little-endian. Bytes 0..3 hold the destination address, bytes 4..7 the byte count and bytes 8..11 the flags word. The values in bytes 12..15 have no effect on what is written.
- R3: Payload byte k of a block is stored at destination+k. Writes carry word-aligned addresses (bits 1:0 zero) and 32-bit little-endian data, and byte lane = address bits 1:0. `mem_be` marks exactly the bytes carried, so partial first and last words use byte enables. A block makes one write for each 32-bit word it spans.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_wdata` and `mem_be` hold their values.
- R5: After the byte that completes a word is accepted, `host_wait` is high from the next cycle until the write is accepted, and it is low again in the cycle after acceptance. A byte offered while `host_wait` is high is ignored.
- R6: When flags bit 1 is set (fill), no payload bytes are taken from the stream. The count's worth of bytes from the destination onward are written as zero, and the next stream byte starts the next header.
- R7: A block with a byte count of zero makes no write, and the next stream byte starts the next header.
- R8: Any number of blocks load in sequence. After the accepted final write of a block whose flags bit 0 is set, `boot_done` rises in the following cycle and stays high. `entry_addr` equals the ENTRY_ADDR parameter.
- R9: Once `boot_done` is high, `host_wait` stays high, no write is issued and input bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a stream byte this cycle |
| in_data | input | 8 | Stream byte |
| host_wait | output | 1 | High while the loader takes no bytes |
| mem_valid | output | 1 | Write request pending |
| mem_addr | output | 32 | Word-aligned write address |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Byte enables, bit n for lane n |
| mem_ready | input | 1 | Memory accepts the pending write |
| boot_done | output | 1 | All blocks are loaded |
| entry_addr | output | 32 | Address where execution starts |

## Verification
The bench sends one boot sequence in which every header is followed straight away by the next block. The sequence includes blocks that start and end on odd byte lanes, a zero-count block, a fill block, a single-word block and memory stalls of several lengths. If a design fed fill blocks or zero-count blocks from the stream, the headers after them would fall out of step and every later block would land at a wrong address. The bench offers junk bytes whenever `host_wait` is high, so a loader that accepted bytes during a stall would write corrupted data. A directed run holds `mem_ready` low on a full word. It checks that the request and `host_wait` stay put and that pacing is released one cycle after the write is accepted. Wrong byte enables on partial words would show up as extra or missing bytes in the memory image the bench builds.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    localparam int HDR_BYTES  = 16;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int HDR_W      = 8 * HDR_BYTES;
    localparam int NLANE_W    = LANE_W + 1;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_DATA,
        ST_FILL,
        ST_ENDBLK,
        ST_DONE
    } bsl_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] dest;
        logic [WORD_W-1:0] count;
        logic              last;
        logic              fill;
    } bsl_hdr_t;

    typedef struct packed {
        logic [WORD_W-1:0]     addr;
        logic [WORD_W-1:0]     data;
        logic [WORD_BYTES-1:0] be;
    } bsl_wr_t;

    // Split a raw little-endian header into its fields.
    function automatic bsl_hdr_t decode_hdr(input logic [HDR_W-1:0] raw);
        bsl_hdr_t h;
        h.dest  = raw[WORD_W-1:0];
        h.count = raw[2*WORD_W-1:WORD_W];
        h.last  = raw[2*WORD_W];
        h.fill  = raw[2*WORD_W+1];
        return h;
    endfunction

    // Enable mask for n bytes (1..WORD_BYTES) starting at a lane.
    function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [LANE_W-1:0] lane,
                                                         input logic [NLANE_W-1:0] n);
        logic [WORD_BYTES-1:0] m;
        if (n[LANE_W])
            m = '1;
        else
            m = (WORD_BYTES'(1) << n[LANE_W-1:0]) - WORD_BYTES'(1);
        return m << lane;
    endfunction

endpackage

// File: rtl/bsl_hdr_collect.sv
module bsl_hdr_collect
    import bsl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic [7:0] byte_in,
    output logic     complete,
    output bsl_hdr_t hdr
);
    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam int SHR_W = HDR_W - 8;

    logic [IDX_W-1:0] idx_q;
    logic [SHR_W-1:0] shr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            shr_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + IDX_W'(1);
            shr_q <= {byte_in, shr_q[SHR_W-1:8]};
        end
    end

    assign complete = take && (idx_q == IDX_W'(HDR_BYTES - 1));
    assign hdr      = decode_hdr({byte_in, shr_q});

endmodule

// File: rtl/bsl_wr_port.sv
module bsl_wr_port
    import bsl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue,
    input  bsl_wr_t               req,
    input  logic                  mem_ready,
    output logic                  busy,
    output logic                  mem_valid,
    output logic [WORD_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    output logic [WORD_BYTES-1:0] mem_be
);
    logic    vld_q;
    bsl_wr_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            hold_q <= '0;
        end else if (issue) begin
            vld_q  <= 1'b1;
            hold_q <= req;
        end else if (vld_q && mem_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign busy      = vld_q;
    assign mem_valid = vld_q;
    assign mem_addr  = hold_q.addr;
    assign mem_wdata = hold_q.data;
    assign mem_be    = hold_q.be;

    p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[LANE_W-1:0] == '0) && (mem_be != '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr)
                                      && $stable(mem_wdata) && $stable(mem_be));

    p_no_clobber_r4: assert property (@(posedge clk) disable iff (rst)
        issue |-> !mem_valid);

endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader
    import bsl_pkg::*;
#(
    parameter logic [31:0] ENTRY_ADDR = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        host_wait,
    output logic        mem_valid,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic        mem_ready,
    output logic        boot_done,
    output logic [31:0] entry_addr
);
    bsl_state_e            st_q;
    logic [WORD_W-1:0]     cur_q;
    logic [WORD_W-1:0]     left_q;
    logic                  last_q;
    logic [WORD_W-1:0]     acc_data_q;
    logic [WORD_BYTES-1:0] acc_be_q;

    logic     busy;
    logic     take;
    logic     hdr_done;
    bsl_hdr_t hdr;

    logic [LANE_W-1:0]     lane;
    logic [WORD_W-1:0]     merged_data;
    logic [WORD_BYTES-1:0] merged_be;
    logic                  flush;
    logic [NLANE_W-1:0]    room;
    logic [NLANE_W-1:0]    fill_n;
    logic                  issue;
    bsl_wr_t               req;

    assign host_wait = busy || (st_q == ST_FILL) || (st_q == ST_ENDBLK) || (st_q == ST_DONE);
    assign take      = in_valid && !host_wait;
    assign boot_done = (st_q == ST_DONE);
    assign entry_addr = ENTRY_ADDR;

    bsl_hdr_collect u_hdr (
        .clk      (clk),
        .rst      (rst),
        .take     (take && (st_q == ST_HDR)),
        .byte_in  (in_data),
        .complete (hdr_done),
        .hdr      (hdr)
    );

    // Byte merge for streamed payload and span size for fill writes.
    assign lane = cur_q[LANE_W-1:0];
    always_comb begin
        merged_data = acc_data_q;
        merged_data[{lane, 3'b000} +: 8] = in_data;
        merged_be = acc_be_q | (WORD_BYTES'(1) << lane);
        flush = (lane == LANE_W'(WORD_BYTES - 1)) || (left_q == WORD_W'(1));
        room = NLANE_W'(WORD_BYTES) - {1'b0, lane};
        fill_n = (left_q < WORD_W'(room)) ? left_q[NLANE_W-1:0] : room;
    end

    always_comb begin
        issue = 1'b0;
        req   = '0;
        case (st_q)
            ST_DATA: begin
                if (take && flush) begin
                    issue     = 1'b1;
                    req.addr  = {cur_q[WORD_W-1:LANE_W], LANE_W'(0)};
                    req.data  = merged_data;
                    req.be    = merged_be;
                end
            end
            ST_FILL: begin
                if (!busy) begin
                    issue     = 1'b1;
                    req.addr  = {cur_q[WORD_W-1:LANE_W], LANE_W'(0)};
                    req.data  = '0;
                    req.be    = lane_mask(lane, fill_n);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HDR;
            cur_q      <= '0;
            left_q     <= '0;
            last_q     <= 1'b0;
            acc_data_q <= '0;
            acc_be_q   <= '0;
        end else begin
            case (st_q)
                ST_HDR: begin
                    if (hdr_done) begin
                        cur_q      <= hdr.dest;
                        left_q     <= hdr.count;
                        last_q     <= hdr.last;
                        acc_data_q <= '0;
                        acc_be_q   <= '0;
                        if (hdr.count == '0)
                            st_q <= ST_ENDBLK;
                        else if (hdr.fill)
                            st_q <= ST_FILL;
                        else
                            st_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (take) begin
                        cur_q  <= cur_q + WORD_W'(1);
                        left_q <= left_q - WORD_W'(1);
                        if (flush) begin
                            acc_data_q <= '0;
                            acc_be_q   <= '0;
                        end else begin
                            acc_data_q <= merged_data;
                            acc_be_q   <= merged_be;
                        end
                        if (left_q == WORD_W'(1))
                            st_q <= ST_ENDBLK;
                    end
                end
                ST_FILL: begin
                    if (!busy) begin
                        cur_q  <= cur_q + WORD_W'(fill_n);
                        left_q <= left_q - WORD_W'(fill_n);
                        if (left_q == WORD_W'(fill_n))
                            st_q <= ST_ENDBLK;
                    end
                end
                ST_ENDBLK: begin
                    if (!busy || mem_ready)
                        st_q <= last_q ? ST_DONE : ST_HDR;
                end
                default: st_q <= ST_DONE;
            endcase
        end
    end

    bsl_wr_port u_wr (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .req       (req),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be)
    );

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && (st_q == ST_DATA)) |=> !host_wait);

    p_data_left_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA) |-> (left_q != '0));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done);

    p_quiet_done_r9: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> !mem_valid && host_wait);

endmodule

// File: tb/boot_stream_loader_tb.sv
module boot_stream_loader_tb_top;

    localparam logic [31:0] ENTRY = 32'h0000_1000;
    localparam int NBLK = 6;
    localparam logic [31:0] T_ADDR  [NBLK] = '{32'h100, 32'h203, 32'h300, 32'h402, 32'h501, 32'h600};
    localparam logic [31:0] T_COUNT [NBLK] = '{32'd8,   32'd7,   32'd0,   32'd9,   32'd2,   32'd5};
    localparam logic [31:0] T_FLAGS [NBLK] = '{32'd0,   32'd0,   32'd0,   32'd2,   32'd0,   32'd1};
    localparam int          T_STALL [NBLK] = '{0, 2, 0, 3, 1, 0};
    localparam int          T_WRITES = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        host_wait;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic        boot_done;
    logic [31:0] entry_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int nwrites = 0;
    int stall = 0;
    int wait_cnt = 0;
    bit auto_mode = 1'b1;
    bit man_ready = 1'b0;
    bit inject = 1'b0;
    bit finished = 1'b0;
    logic [7:0] got [int unsigned];
    logic [7:0] expd [int unsigned];

    always #4 clk = ~clk;

    boot_stream_loader #(.ENTRY_ADDR(ENTRY)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .host_wait(host_wait), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
        .boot_done(boot_done), .entry_addr(entry_addr)
    );

    // Memory model: picks ready just after the falling edge and logs the
    // transfer that completes at the following rising edge.
    always @(negedge clk) begin
        #1;
        if (auto_mode) begin
            if (mem_valid && wait_cnt >= stall) begin
                mem_ready = 1'b1;
                wait_cnt = 0;
            end else begin
                mem_ready = 1'b0;
                wait_cnt = mem_valid ? wait_cnt + 1 : 0;
            end
        end else begin
            mem_ready = man_ready;
        end
        if (mem_valid && mem_ready && !rst) begin
            nwrites++;
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) got[mem_addr + i] = mem_wdata[8*i +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!host_wait && !mem_valid && !boot_done, "R1", "outputs in reset",
            {host_wait, mem_valid, boot_done}, 0);
        rst = 1'b0;
        got.delete();
        expd.delete();
        nwrites = 0;
        wait_cnt = 0;
        @(negedge clk);
        chk(!host_wait && !mem_valid && !boot_done, "R1", "outputs after reset",
            {host_wait, mem_valid, boot_done}, 0);
    endtask

    // Called at a falling edge; returns at a falling edge once the byte is taken.
    task automatic send_byte(input logic [7:0] b);
        while (host_wait) begin
            in_valid = inject;
            in_data = 8'hEE;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_header(input logic [31:0] a, input logic [31:0] c, input logic [31:0] f);
        for (int i = 0; i < 4; i++) send_byte(a[8*i +: 8]);
        for (int i = 0; i < 4; i++) send_byte(c[8*i +: 8]);
        for (int i = 0; i < 4; i++) send_byte(f[8*i +: 8]);
        for (int i = 0; i < 4; i++) send_byte(8'hA5 ^ 8'(i * 3));
    endtask

    function automatic logic [7:0] pay(input int b, input int k);
        return 8'(b * 37 + k * 11 + 5);
    endfunction

    task automatic wait_done();
        for (int i = 0; i < 100 && !boot_done; i++) @(negedge clk);
    endtask

    task automatic compare_image(input string req, input string what);
        int bad = 0;
        foreach (expd[a]) if (!got.exists(a) || got[a] !== expd[a]) bad++;
        chk(bad == 0, req, what, bad, 0);
        chk(got.num() == expd.num(), req, {what, " byte total"}, got.num(), expd.num());
    endtask

    initial begin
        int wr_before;
        logic [31:0] held;

        // Sequence A: table of blocks sent as one boot stream.
        auto_mode = 1'b1;
        do_reset();
        inject = 1'b1;
        for (int b = 0; b < NBLK; b++) begin
            stall = T_STALL[b];
            send_header(T_ADDR[b], T_COUNT[b], T_FLAGS[b]);
            for (int k = 0; k < int'(T_COUNT[b]); k++) begin
                if (T_FLAGS[b][1]) expd[T_ADDR[b] + k] = 8'h00;           // R6 zero fill
                else begin
                    expd[T_ADDR[b] + k] = pay(b, k);                       // R2 R3 placement
                    send_byte(pay(b, k));
                end
            end
            if (!T_FLAGS[b][0])
                chk(!boot_done, "R8", "done before final block", boot_done, 0);
        end
        inject = 1'b0;
        wait_done();
        chk(boot_done, "R8", "done after final block", boot_done, 1);
        chk(entry_addr == ENTRY, "R8", "entry address", entry_addr, ENTRY);
        compare_image("R3", "block image (R2 R5 R6)");
        chk(nwrites == T_WRITES, "R3", "write count", nwrites, T_WRITES);
        chk(!got.exists(32'h300), "R7", "zero-count block wrote", got.exists(32'h300), 0);

        // R9: bytes after completion are ignored.
        wr_before = nwrites;
        in_valid = 1'b1;
        in_data = 8'h5A;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(nwrites == wr_before, "R9", "writes after done", nwrites, wr_before);
        chk(host_wait && boot_done, "R9", "wait and done held", {host_wait, boot_done}, 3);

        // Sequence B: directed pacing and stall hold.
        auto_mode = 1'b0;
        man_ready = 1'b0;
        do_reset();
        send_header(32'h800, 32'd8, 32'd1);
        chk(!host_wait, "R5", "wait low during header", host_wait, 0);
        for (int k = 0; k < 4; k++) send_byte(8'h10 + 8'(k));
        chk(mem_valid && host_wait, "R5", "wait high on full word", {mem_valid, host_wait}, 3);
        chk(mem_addr == 32'h800, "R3", "word address", mem_addr, 32'h800);
        chk(mem_wdata == 32'h1312_1110, "R3", "little-endian data", mem_wdata, 32'h1312_1110);
        chk(mem_be == 4'hF, "R3", "full enables", mem_be, 4'hF);
        held = mem_wdata;
        in_valid = 1'b1;
        in_data = 8'hEE;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk(mem_valid && host_wait, "R4", "request held in stall", {mem_valid, host_wait}, 3);
        chk(mem_wdata == held && mem_addr == 32'h800, "R4", "data stable in stall", mem_wdata, held);
        man_ready = 1'b1;
        @(negedge clk);
        man_ready = 1'b0;
        chk(!host_wait && !mem_valid, "R5", "wait released after accept",
            {host_wait, mem_valid}, 0);
        auto_mode = 1'b1;
        stall = 1;
        for (int k = 4; k < 8; k++) send_byte(8'h10 + 8'(k));
        for (int k = 0; k < 8; k++) expd[32'h800 + k] = 8'h10 + 8'(k);
        wait_done();
        chk(boot_done, "R8", "single final block done", boot_done, 1);
        compare_image("R5", "image after stall with junk offered");
        chk(nwrites == 2, "R3", "two word writes", nwrites, 2);

        finished = 1'b1;
        summary();
    end

endmodule